// File: doc/BRIEF.md
# Dual-Band Programmable Feedback Divider

This block is the frequency-setting divider in the feedback path of a tuning synthesizer. It receives two VCO event streams that have already been squared and sampled into the system clock domain. Each is a one-cycle strobe per VCO edge. The low-band stream goes straight into a programmable down-counter. The high-band stream first passes through a fixed decade prescaler. A band-select pin picks which stream drives the counter. The counter emits a one-cycle pulse each time it has seen the programmed number of source events. A level that toggles on every pulse is also provided as a test output.

The divide ratio arrives as a 15-bit word on a valid/ready stream, together with a mode bit that sets how the word is applied. In immediate mode the word is accepted whenever `word_ready` is high and is forced into the counter at once. This suits large jumps. In boundary mode the word is held pending, and the division cycle already in progress finishes with the old ratio before the new one applies. This suits small steps of up to about 31 tuning steps. While a boundary-mode word is pending, `word_ready` stays low, so the producer has to hold `word_valid` and `word_data` until `word_ready` rises again. A transfer happens only in a cycle where `word_valid` and `word_ready` are both high.

Top module: `dual_band_divider`

## Requirements
- R1: After reset `div_pulse` is 0, `div_toggle` is 0 and `word_ready` is 1. The low band (`band_sel` = 0) is active with a ratio of 512, so the first pulse arrives after 512 low-band events.
- R2: With `band_sel` = 0, exactly one pulse is produced per N `lo_tick` events, where N is the active ratio. `hi_tick` has no effect on this count.
- R3: With `band_sel` = 1, exactly one pulse is produced per 10·N `hi_tick` events. `lo_tick` has no effect on this count.
- R4: `div_pulse` is high for exactly one cycle. It rises in the cycle after the clock edge that takes the terminal source event.
- R5: An accepted word with `word_sync` = 0 reloads the counter at once. Any source event in the accept cycle is discarded. No pulse follows in the next cycle, and the next pulse comes after exactly N source events counted from the cycle after acceptance.
- R6: An accepted word with `word_sync` = 1 leaves the current division cycle at its old ratio. The new ratio governs the cycle that follows.
- R7: `word_ready` falls in the cycle after a `word_sync` = 1 transfer. It rises again in the same cycle as the boundary pulse, and a word offered while it is low is ignored. An immediate transfer leaves `word_ready` high.
- R8: Any ratio below 512 (for example 0, 100 or 511) is used as 512.
- R9: A change of `band_sel` clears the prescaler and restarts the counter at the active ratio. A source event in the switch cycle is discarded, no pulse follows in the next cycle, and the first full period on the new band is exact.
- R10: `div_toggle` inverts in the cycle of every pulse and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_sel | input | 1 | 1 = high band through the decade prescaler, 0 = low band direct |
| lo_tick | input | 1 | Low-band VCO event strobe |
| hi_tick | input | 1 | High-band VCO event strobe |
| word_valid | input | 1 | Ratio word offered |
| word_ready | output | 1 | Divider can take a ratio word |
| word_data | input | 15 | Requested divide ratio |
| word_sync | input | 1 | 1 = apply at cycle boundary, 0 = apply at once |
| div_pulse | output | 1 | One-cycle pulse per completed division |
| div_toggle | output | 1 | Level that inverts on each pulse (test output) |

## Verification
The bench drives random events on both inputs at the same time. A design that leaks the unselected band into the count therefore shows a wrong period, as does a prescaler off by one in its modulus. A boundary-mode word is offered right after a pulse, together with a rejected immediate word during the pending window. A design that applies the word early, or that accepts it while busy, shows the new period one cycle too soon. Band switches and immediate loads are measured from the first period afterwards, which catches a prescaler left uncleared or a stale event counted in the load cycle. Ratios 0, 100, 511 and 512 probe the clamp edge, and a design without the clamp would wrap to a tiny or zero count.

// File: rtl/dual_band_divider_pkg.sv
`timescale 1ns/1ps
package dual_band_divider_pkg;
  localparam int unsigned RATIO_W_DEF   = 15;
  localparam int unsigned MIN_RATIO_DEF = 512;
  localparam int unsigned HI_DIV_DEF    = 10;

  typedef enum logic {BAND_LO = 1'b0, BAND_HI = 1'b1} band_e;
endpackage

// File: rtl/decade_prescaler.sv
`timescale 1ns/1ps
module decade_prescaler #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick_in,
  output logic tick_out
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (clr)
      phase <= '0;
    else if (tick_in)
      phase <= (phase == LAST) ? '0 : phase + CW'(1);
  end

  assign tick_out = tick_in && !clr && (phase == LAST);
endmodule

// File: rtl/ratio_loader.sv
`timescale 1ns/1ps
module ratio_loader #(
  parameter int unsigned W     = 15,
  parameter int unsigned MIN_R = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_valid,
  input  logic [W-1:0] word_data,
  input  logic         word_sync,
  input  logic         boundary,
  output logic         word_ready,
  output logic         imm_load,
  output logic [W-1:0] imm_val,
  output logic [W-1:0] active,
  output logic [W-1:0] reload_val
);
  localparam logic [W-1:0] FLOOR = W'(MIN_R);

  logic         pending;
  logic [W-1:0] pend_val;
  logic         accept;
  logic [W-1:0] clamped;

  assign word_ready = !pending;
  assign accept     = word_valid && word_ready;
  assign clamped    = (word_data < FLOOR) ? FLOOR : word_data;
  assign imm_load   = accept && !word_sync;
  assign imm_val    = clamped;
  assign reload_val = pending ? pend_val : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      pend_val <= FLOOR;
      active   <= FLOOR;
    end else begin
      if (imm_load)
        active <= clamped;
      else if (boundary && pending)
        active <= pend_val;

      if (accept && word_sync) begin
        pending  <= 1'b1;
        pend_val <= clamped;
      end else if (boundary) begin
        pending  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prog_down_counter.sv
`timescale 1ns/1ps
module prog_down_counter #(
  parameter int unsigned W     = 15,
  parameter int unsigned MIN_R = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_tick,
  input  logic         force_load,
  input  logic [W-1:0] force_val,
  input  logic         restart,
  input  logic [W-1:0] restart_val,
  input  logic [W-1:0] reload_val,
  output logic         terminal,
  output logic         pulse,
  output logic         toggle
);
  logic [W-1:0] count;

  assign terminal = src_tick && !force_load && !restart && (count == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= W'(MIN_R);
      pulse  <= 1'b0;
      toggle <= 1'b0;
    end else begin
      pulse <= terminal;
      if (terminal)
        toggle <= ~toggle;

      if (force_load)
        count <= force_val;
      else if (restart)
        count <= restart_val;
      else if (src_tick)
        count <= (count == W'(1)) ? reload_val : count - W'(1);
    end
  end
endmodule

// File: rtl/dual_band_divider.sv
`timescale 1ns/1ps
module dual_band_divider
  import dual_band_divider_pkg::*;
#(
  parameter int unsigned RATIO_W   = RATIO_W_DEF,
  parameter int unsigned MIN_RATIO = MIN_RATIO_DEF,
  parameter int unsigned HI_DIV    = HI_DIV_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               band_sel,
  input  logic               lo_tick,
  input  logic               hi_tick,
  input  logic               word_valid,
  output logic               word_ready,
  input  logic [RATIO_W-1:0] word_data,
  input  logic               word_sync,
  output logic               div_pulse,
  output logic               div_toggle
);
  band_e              band_q;
  logic               switching;
  logic               pre_tick;
  logic               src_tick;
  logic               terminal;
  logic               imm_load;
  logic [RATIO_W-1:0] imm_val;
  logic [RATIO_W-1:0] active;
  logic [RATIO_W-1:0] reload_val;

  assign switching = (band_e'(band_sel) != band_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) band_q <= BAND_LO;
    else        band_q <= band_e'(band_sel);
  end

  decade_prescaler #(.DIV(HI_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (switching),
    .tick_in  (hi_tick),
    .tick_out (pre_tick)
  );

  assign src_tick = !switching && ((band_q == BAND_HI) ? pre_tick : lo_tick);

  ratio_loader #(.W(RATIO_W), .MIN_R(MIN_RATIO)) u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_sync  (word_sync),
    .boundary   (terminal),
    .word_ready (word_ready),
    .imm_load   (imm_load),
    .imm_val    (imm_val),
    .active     (active),
    .reload_val (reload_val)
  );

  prog_down_counter #(.W(RATIO_W), .MIN_R(MIN_RATIO)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_tick    (src_tick),
    .force_load  (imm_load),
    .force_val   (imm_val),
    .restart     (switching),
    .restart_val (active),
    .reload_val  (reload_val),
    .terminal    (terminal),
    .pulse       (div_pulse),
    .toggle      (div_toggle)
  );
endmodule

// File: rtl/dual_band_divider_chk.sv
`timescale 1ns/1ps
module dual_band_divider_chk (
  input logic clk,
  input logic rst_n,
  input logic band_sel,
  input logic band_q,
  input logic word_valid,
  input logic word_ready,
  input logic word_sync,
  input logic div_pulse,
  input logic div_toggle
);
  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R7
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && word_sync) |=> !word_ready);

  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_ready) |-> div_pulse);

  // R7
  imm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && !(word_valid && word_sync)) |=> word_ready);

  // R5
  imm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && !word_sync) |=> !div_pulse);

  // R9
  switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (band_sel != band_q) |=> !div_pulse);

  // R10
  toggle_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_toggle != $past(div_toggle)) |-> div_pulse);
endmodule

bind dual_band_divider dual_band_divider_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .band_sel   (band_sel),
  .band_q     (band_q),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .word_sync  (word_sync),
  .div_pulse  (div_pulse),
  .div_toggle (div_toggle)
);

// File: tb/dual_band_divider_tb.sv
`timescale 1ns/1ps
module dual_band_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        band_sel = 1'b0;
  logic        lo_tick = 1'b0;
  logic        hi_tick = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [14:0] word_data = '0;
  logic        word_sync = 1'b0;
  logic        div_pulse;
  logic        div_toggle;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit band_cur = 0;
  int cur_ratio = 512;

  always #2.5 clk = ~clk;

  dual_band_divider u_dut (
    .clk(clk), .rst_n(rst_n), .band_sel(band_sel), .lo_tick(lo_tick),
    .hi_tick(hi_tick), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .word_sync(word_sync), .div_pulse(div_pulse),
    .div_toggle(div_toggle)
  );

  function automatic int clamp_ratio(int r);
    return (r < 512) ? 512 : r;
  endfunction

  function automatic int exp_period(bit band, int r);
    return clamp_ratio(r) * (band ? 10 : 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit lo, bit hi);
    lo_tick = lo;
    hi_tick = hi;
    @(posedge clk);
    #1;
  endtask

  // Random events on both inputs; count only the selected band's events.
  task automatic measure(int exp, string req);
    int cnt = 0;
    bit seen = 0;
    bit tog_before = 0;
    bit tog_ok = 0;
    while (!seen) begin
      bit lo = ($urandom % 4) != 0;
      bit hi = ($urandom % 8) != 0;
      tog_before = div_toggle;
      cyc(lo, hi);
      cnt += band_cur ? int'(hi) : int'(lo);
      if (div_pulse) begin
        seen = 1;
        tog_ok = (div_toggle != tog_before);
      end
    end
    chk(cnt == exp, req, cnt, exp);
    chk(tog_ok, "R10 toggle flips on pulse", int'(div_toggle), int'(!tog_before));
    cyc(0, 0);
    chk(div_pulse == 1'b0, "R4 pulse one cycle wide", int'(div_pulse), 0);
  endtask

  task automatic load_word(int data, bit sync);
    word_valid = 1'b1;
    word_data  = 15'(data);
    word_sync  = sync;
    cyc(0, 0);
    word_valid = 1'b0;
    if (sync) begin
      chk(word_ready == 1'b0, "R7 ready low after boundary-mode word", int'(word_ready), 0);
    end else begin
      chk(div_pulse == 1'b0, "R5 no pulse after immediate load", int'(div_pulse), 0);
      chk(word_ready == 1'b1, "R7 ready stays high after immediate word", int'(word_ready), 1);
      cur_ratio = clamp_ratio(data);
    end
  endtask

  task automatic set_band(bit b);
    band_sel = b;
    cyc(0, 0);
    band_cur = b;
    chk(div_pulse == 1'b0, "R9 no pulse after band switch", int'(div_pulse), 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(div_pulse == 1'b0, "R1 pulse low after reset", int'(div_pulse), 0);
    chk(div_toggle == 1'b0, "R1 toggle low after reset", int'(div_toggle), 0);
    chk(word_ready == 1'b1, "R1 ready high after reset", int'(word_ready), 1);
    measure(512, "R1 first low-band period 512");

    // R2 low band, hi_tick ignored
    load_word(700, 0);
    measure(700, "R2 low-band period");
    measure(700, "R2 low-band period repeat");

    // R5 immediate load mid-period
    for (int i = 0; i < 150; i++) cyc(1, 1);
    load_word(900, 0);
    measure(900, "R5 period after immediate load");

    // R6/R7 boundary load, with a rejected immediate word while pending
    load_word(600, 1);
    word_valid = 1'b1; word_data = 15'd1000; word_sync = 1'b0;
    cyc(0, 0);
    word_valid = 1'b0;
    chk(word_ready == 1'b0, "R7 ready held low while pending", int'(word_ready), 0);
    measure(900, "R6 old ratio finishes cycle");
    measure(600, "R6 new ratio after boundary");
    cur_ratio = 600;
    chk(word_ready == 1'b1, "R7 ready back after boundary", int'(word_ready), 1);

    // R8 clamp
    load_word(100, 0);
    measure(512, "R8 ratio 100 clamps to 512");
    load_word(0, 0);
    measure(512, "R8 ratio 0 clamps to 512");
    load_word(511, 0);
    measure(512, "R8 ratio 511 clamps to 512");
    load_word(513, 0);
    measure(513, "R8 ratio 513 kept");

    // R9/R3 band switch to high band
    load_word(520, 0);
    set_band(1);
    measure(exp_period(1, 520), "R9 first high-band period after switch");
    measure(exp_period(1, 520), "R3 high-band period");
    // R9 switch mid-period back to low band
    for (int i = 0; i < 77; i++) cyc(1, 1);
    set_band(0);
    measure(520, "R9 first low-band period after switch");

    // Random mix
    for (int it = 0; it < 5; it++) begin
      bit b = 1'($urandom % 2);
      bit s = 1'($urandom % 2);
      int r = b ? (512 + int'($urandom % 150)) : (400 + int'($urandom % 1200));
      if (b != band_cur) set_band(b);
      if (s) begin
        load_word(r, 1);
        measure(exp_period(band_cur, cur_ratio), band_cur ? "R6 R3 old ratio random" : "R6 R2 old ratio random");
        cur_ratio = clamp_ratio(r);
        measure(exp_period(band_cur, cur_ratio), band_cur ? "R6 R3 new ratio random" : "R6 R2 new ratio random");
      end else begin
        load_word(r, 0);
        measure(exp_period(band_cur, cur_ratio), band_cur ? "R5 R3 random" : "R5 R2 random");
      end
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule